// File: doc/BRIEF.md
# Processor Bus Controller with Clock-Stretch Wait States

This block connects a 32-bit processor bus to external memories and to two groups of on-chip registers. On every processor cycle it takes the request, the direction, the byte/word size and the segment bits of the address. From these it drives registered active-low chip selects for four external devices, an active-low read strobe and four active-low byte write strobes.

The block also produces the processor clock itself, from a reference clock running `REF_DIV` times faster. Slow targets get their extra time by holding the processor clock in one of its phases, so the processor needs no ready input. Each wait state is one full processor period. The ROM, EEPROM and spare counts come from a small wait-state register that software loads through a write port. The on-chip register groups use fixed counts. Correlator accesses that come close together get extra waits so that the correlator's minimum spacing is kept. After a read from a slow external device, the next processor cycle is lengthened by one reference tick so the device can release the data bus.

A processor cycle starts at a falling edge of `mclk`. The request inputs are sampled on the reference-clock edge that starts the cycle. The strobes stay constant until the next falling edge.

Top module: `memwait_ctrl`

## Requirements
- R1: Segment code `seg` selects the target: 0 ROM, 1 RAM, 2 correlator registers, 3 support registers, 4 EEPROM, 5 spare, 6 and 7 nothing. A requested access to 0, 1, 4 or 5 drives exactly one of `rom_cs_n`, `ram_cs_n`, `eep_cs_n`, `spr_cs_n` low. Codes 2, 3, 6 and 7, and cycles without `req`, leave all four high.
- R2: `rd_n` is low for the whole cycle of a requested read (`wr_en`=0) to an external target (codes 0, 1, 4, 5). It is high otherwise, and it is never low while any `wr_n` bit is low.
- R3: A requested write to an external target pulls all four `wr_n` bits low. The exception is a byte write (`byte_en`=1) to RAM, which pulls only `wr_n[lane]` low. `byte_en` has no effect on other targets.
- R4: A processor cycle lasts `REF_DIV` reference ticks (4 by default) plus `REF_DIV` ticks per wait state plus any recovery tick. Idle cycles, RAM accesses and codes 6 and 7 take no wait states.
- R5: A ROM access takes the ROM count from the wait-state register, in the range 1 to 3.
- R6: EEPROM and spare accesses each take their own count from the wait-state register, in the range 3 to 6.
- R7: A support-register access takes exactly one wait state.
- R8: A correlator access takes one wait state. When fewer than `CORR_GAP` (2) cycles have started since the previous correlator access, it takes `CORR_EXTRA` (2) more.
- R9: A read from ROM, EEPROM or spare adds one reference tick to the following cycle, whether or not that cycle has a request. RAM reads add nothing.
- R10: After reset the wait-state register holds 3 (ROM), 6 (EEPROM) and 6 (spare). A write with `wsr_we` stores each field clamped into its range. The new values apply from the next cycle that starts after the write.
- R11: During reset `mclk` is high and all strobes are inactive. Stretching holds `mclk` low, so the high phase is always `REF_DIV/2` ticks. Strobes change only at the start of a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Processor memory request |
| wr_en | input | 1 | 1 = write, 0 = read |
| byte_en | input | 1 | 1 = byte write, 0 = word |
| seg | input | 3 | Segment bits of the address |
| lane | input | 2 | Byte-select address bits |
| wsr_we | input | 1 | Wait-state register write enable |
| wsr_rom | input | WS_W | ROM wait count to store |
| wsr_eep | input | WS_W | EEPROM wait count to store |
| wsr_spr | input | WS_W | Spare wait count to store |
| mclk | output | 1 | Stretched processor clock |
| rom_cs_n | output | 1 | ROM chip select |
| ram_cs_n | output | 1 | RAM chip select |
| eep_cs_n | output | 1 | EEPROM chip select |
| spr_cs_n | output | 1 | Spare chip select |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 4 | Byte write strobes, bit n = byte lane n |

## Verification
The correlator spacing window is the hardest behaviour to reach. Whether the penalty applies depends on how many cycles, idle ones included, have started since the last correlator access. The same count also has to line up with recovery ticks and with wait-state register writes landing mid-cycle. Directed runs place correlator accesses back to back and with one or two idle cycles between them. Random traffic then mixes all segments with occasional register writes, including out-of-range values. A bench model tracks the window, the pending recovery and the register contents for every cycle. Cycle lengths are measured from the falling edges of `mclk`.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

   typedef enum logic [2:0] {
      SEG_ROM  = 3'd0,
      SEG_RAM  = 3'd1,
      SEG_CORR = 3'd2,
      SEG_SUPP = 3'd3,
      SEG_EEP  = 3'd4,
      SEG_SPR  = 3'd5,
      SEG_NC6  = 3'd6,
      SEG_NC7  = 3'd7
   } seg_e;

   // external targets own a chip select
   function automatic logic seg_is_ext(seg_e s);
      return (s == SEG_ROM) || (s == SEG_RAM) || (s == SEG_EEP) || (s == SEG_SPR);
   endfunction

   // targets slow enough to need bus-release recovery after a read
   function automatic logic seg_is_slow(seg_e s);
      return (s == SEG_ROM) || (s == SEG_EEP) || (s == SEG_SPR);
   endfunction

endpackage

// File: rtl/mwc_decode.sv
module mwc_decode
   import mwc_pkg::*;
(
   input  logic       req,
   input  logic       wr_en,
   input  logic       byte_en,
   input  logic [2:0] seg,
   input  logic [1:0] lane,
   output seg_e       seg_q,
   output logic [3:0] cs_n,
   output logic       rd_n,
   output logic [3:0] wr_n,
   output logic       slow_rd
);

   logic ext_hit;
   logic byte_mode;

   assign seg_q     = seg_e'(seg);
   assign ext_hit   = req && seg_is_ext(seg_q);
   assign byte_mode = byte_en && (seg_q == SEG_RAM);
   assign rd_n      = !(ext_hit && !wr_en);
   assign slow_rd   = req && !wr_en && seg_is_slow(seg_q);

   // chip select order: [0] ROM, [1] RAM, [2] EEPROM, [3] spare
   always_comb begin
      cs_n = 4'hF;
      if (req) begin
         case (seg_q)
            SEG_ROM: cs_n[0] = 1'b0;
            SEG_RAM: cs_n[1] = 1'b0;
            SEG_EEP: cs_n[2] = 1'b0;
            SEG_SPR: cs_n[3] = 1'b0;
            default: cs_n = 4'hF;
         endcase
      end
   end

   for (genvar i = 0; i < 4; i++) begin : g_lane
      logic lane_on;
      assign lane_on = !byte_mode || (lane == 2'(i));
      assign wr_n[i] = !(ext_hit && wr_en && lane_on);
   end

endmodule

// File: rtl/mwc_wsreg.sv
module mwc_wsreg #(
   parameter int WS_W     = 3,
   parameter int ROM_MIN  = 1,
   parameter int ROM_MAX  = 3,
   parameter int SLOW_MIN = 3,
   parameter int SLOW_MAX = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [WS_W-1:0] rom_in,
   input  logic [WS_W-1:0] eep_in,
   input  logic [WS_W-1:0] spr_in,
   output logic [WS_W-1:0] rom_ws,
   output logic [WS_W-1:0] eep_ws,
   output logic [WS_W-1:0] spr_ws
);

   if (ROM_MIN < 0 || ROM_MIN > ROM_MAX || ROM_MAX >= (1 << WS_W)) begin : g_bad_rom
      $error("mwc_wsreg: ROM wait range does not fit WS_W");
   end
   if (SLOW_MIN < 0 || SLOW_MIN > SLOW_MAX || SLOW_MAX >= (1 << WS_W)) begin : g_bad_slow
      $error("mwc_wsreg: slow wait range does not fit WS_W");
   end

   function automatic logic [WS_W-1:0] fit(input logic [WS_W-1:0] v, input int lo, input int hi);
      if (int'(v) < lo) return WS_W'(lo);
      if (int'(v) > hi) return WS_W'(hi);
      return v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_ws <= WS_W'(ROM_MAX);
         eep_ws <= WS_W'(SLOW_MAX);
         spr_ws <= WS_W'(SLOW_MAX);
      end else if (we) begin
         rom_ws <= fit(rom_in, ROM_MIN, ROM_MAX);
         eep_ws <= fit(eep_in, SLOW_MIN, SLOW_MAX);
         spr_ws <= fit(spr_in, SLOW_MIN, SLOW_MAX);
      end
   end

   assert_wsr_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(eep_in) >= SLOW_MIN && int'(eep_in) <= SLOW_MAX) |=> (eep_ws == $past(eep_in)));

   assert_wsr_clamp_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(rom_in) > ROM_MAX) |=> (int'(rom_ws) == ROM_MAX));

   assert_wsr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(rom_ws) && $stable(eep_ws) && $stable(spr_ws)));

endmodule

// File: rtl/mwc_clkgen.sv
module mwc_clkgen #(
   parameter int REF_DIV   = 4,
   parameter bit HOLD_HIGH = 1'b0,
   parameter int CNT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] load,
   output logic             cap,
   output logic             mclk
);

   localparam int PH_W = $clog2(REF_DIV);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(REF_DIV - 1);
   localparam logic [PH_W-1:0] HALF_PH = PH_W'(REF_DIV / 2);

   if (REF_DIV < 4 || (REF_DIV % 2) != 0) begin : g_bad_div
      $error("mwc_clkgen: REF_DIV must be even and at least 4");
   end

   // hold point: last low tick, or first high tick
   localparam logic [PH_W-1:0] HOLD_PH = HOLD_HIGH ? HALF_PH : PH_W'(REF_DIV / 2 - 1);

   logic [PH_W-1:0]  ph;
   logic [CNT_W-1:0] cnt;
   logic             holding;

   assign cap     = (ph == LAST_PH);
   assign holding = (ph == HOLD_PH) && (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= LAST_PH;
         cnt <= '0;
      end else if (cap) begin
         ph  <= '0;
         cnt <= load;
      end else if (holding) begin
         cnt <= cnt - 1'b1;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   assign mclk = (ph >= HALF_PH);

   assert_stretch_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      holding |=> ((ph == HOLD_PH) && $stable(mclk)));

   assert_cycle_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (!mclk && ph == '0));

endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
   import mwc_pkg::*;
#(
   parameter int REF_DIV      = 4,
   parameter bit HOLD_HIGH    = 1'b0,
   parameter int WS_W         = 3,
   parameter int ROM_WS_MIN   = 1,
   parameter int ROM_WS_MAX   = 3,
   parameter int SLOW_WS_MIN  = 3,
   parameter int SLOW_WS_MAX  = 6,
   parameter int SUPP_WS      = 1,
   parameter int CORR_WS      = 1,
   parameter int CORR_EXTRA   = 2,
   parameter int CORR_GAP     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            wr_en,
   input  logic            byte_en,
   input  logic [2:0]      seg,
   input  logic [1:0]      lane,
   input  logic            wsr_we,
   input  logic [WS_W-1:0] wsr_rom,
   input  logic [WS_W-1:0] wsr_eep,
   input  logic [WS_W-1:0] wsr_spr,
   output logic            mclk,
   output logic            rom_cs_n,
   output logic            ram_cs_n,
   output logic            eep_cs_n,
   output logic            spr_cs_n,
   output logic            rd_n,
   output logic [3:0]      wr_n
);

   localparam int MAX_A    = (ROM_WS_MAX > SLOW_WS_MAX) ? ROM_WS_MAX : SLOW_WS_MAX;
   localparam int MAX_B    = (SUPP_WS > CORR_WS + CORR_EXTRA) ? SUPP_WS : CORR_WS + CORR_EXTRA;
   localparam int MAX_WS   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_LOAD = REF_DIV * MAX_WS + 1;
   localparam int CNT_W    = $clog2(MAX_LOAD + 1);
   localparam int GAP_W    = $clog2(CORR_GAP + 1);
   localparam logic [CNT_W-1:0] SUPP_L  = CNT_W'(SUPP_WS);
   localparam logic [CNT_W-1:0] CORR_L  = CNT_W'(CORR_WS);
   localparam logic [CNT_W-1:0] CORRX_L = CNT_W'(CORR_WS + CORR_EXTRA);
   localparam logic [CNT_W-1:0] DIV_L   = CNT_W'(REF_DIV);

   if (CORR_GAP < 1 || CNT_W < WS_W) begin : g_bad_cfg
      $error("memwait_ctrl: CORR_GAP must be at least 1 and counter must hold a register field");
   end

   seg_e            seg_d;
   logic [3:0]      cs_d;
   logic            rd_d;
   logic [3:0]      wr_d;
   logic            slow_d;
   logic [WS_W-1:0] rom_ws, eep_ws, spr_ws;
   logic            cap;
   logic [CNT_W-1:0] ws_sel;
   logic [CNT_W-1:0] load;
   logic            rec_pend;
   logic [GAP_W-1:0] corr_cnt;
   logic            corr_hit;
   logic [3:0]      cs_q;
   logic            rd_q;
   logic [3:0]      wr_q;

   mwc_decode u_dec (
      .req     (req),
      .wr_en   (wr_en),
      .byte_en (byte_en),
      .seg     (seg),
      .lane    (lane),
      .seg_q   (seg_d),
      .cs_n    (cs_d),
      .rd_n    (rd_d),
      .wr_n    (wr_d),
      .slow_rd (slow_d)
   );

   mwc_wsreg #(
      .WS_W     (WS_W),
      .ROM_MIN  (ROM_WS_MIN),
      .ROM_MAX  (ROM_WS_MAX),
      .SLOW_MIN (SLOW_WS_MIN),
      .SLOW_MAX (SLOW_WS_MAX)
   ) u_wsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wsr_we),
      .rom_in (wsr_rom),
      .eep_in (wsr_eep),
      .spr_in (wsr_spr),
      .rom_ws (rom_ws),
      .eep_ws (eep_ws),
      .spr_ws (spr_ws)
   );

   mwc_clkgen #(
      .REF_DIV   (REF_DIV),
      .HOLD_HIGH (HOLD_HIGH),
      .CNT_W     (CNT_W)
   ) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .cap   (cap),
      .mclk  (mclk)
   );

   assign corr_hit = req && (seg_d == SEG_CORR);

   always_comb begin
      ws_sel = '0;
      if (req) begin
         case (seg_d)
            SEG_ROM:  ws_sel = CNT_W'(rom_ws);
            SEG_EEP:  ws_sel = CNT_W'(eep_ws);
            SEG_SPR:  ws_sel = CNT_W'(spr_ws);
            SEG_SUPP: ws_sel = SUPP_L;
            SEG_CORR: ws_sel = (corr_cnt != '0) ? CORRX_L : CORR_L;
            default:  ws_sel = '0;
         endcase
      end
   end

   assign load = CNT_W'(ws_sel * DIV_L) + CNT_W'(rec_pend);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 4'hF;
         rd_q     <= 1'b1;
         wr_q     <= 4'hF;
         rec_pend <= 1'b0;
         corr_cnt <= '0;
      end else if (cap) begin
         cs_q     <= cs_d;
         rd_q     <= rd_d;
         wr_q     <= wr_d;
         rec_pend <= slow_d;
         if (corr_hit)
            corr_cnt <= GAP_W'(CORR_GAP);
         else if (corr_cnt != '0)
            corr_cnt <= corr_cnt - 1'b1;
      end
   end

   assign rom_cs_n = cs_q[0];
   assign ram_cs_n = cs_q[1];
   assign eep_cs_n = cs_q[2];
   assign spr_cs_n = cs_q[3];
   assign rd_n     = rd_q;
   assign wr_n     = wr_q;

   assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_q));

   assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_q && wr_q != 4'hF));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !req) |=> (cs_q == 4'hF && rd_q && wr_q == 4'hF));

   assert_strobe_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> ($stable(cs_q) && $stable(rd_q) && $stable(wr_q)));

   assert_corr_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && corr_hit && corr_cnt != '0) |-> (int'(load) >= REF_DIV * (CORR_WS + CORR_EXTRA)));

endmodule

// File: tb/tb_memwait_ctrl.sv
`timescale 1ns/1ps
module tb_memwait_ctrl;

   localparam int REF_DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0, wr_en = 1'b0, byte_en = 1'b0;
   logic [2:0] seg = 3'd0;
   logic [1:0] lane = 2'd0;
   logic       wsr_we = 1'b0;
   logic [2:0] wsr_rom = 3'd0, wsr_eep = 3'd0, wsr_spr = 3'd0;
   logic       mclk, rom_cs_n, ram_cs_n, eep_cs_n, spr_cs_n, rd_n;
   logic [3:0] wr_n;

   int total = 0;
   int bad = 0;
   int ticks = 0;

   // bench model state
   int  m_rom = 3, m_eep = 6, m_spr = 6;
   bit  m_rec = 0;
   int  m_corr = 0;
   bit  have_prev = 0;
   int  prev_len = 0;
   string prev_tag = "R4";
   bit  prev_mclk = 1'b1;
   bit  cfg_pend = 0;

   memwait_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .byte_en(byte_en),
      .seg(seg), .lane(lane), .wsr_we(wsr_we), .wsr_rom(wsr_rom),
      .wsr_eep(wsr_eep), .wsr_spr(wsr_spr), .mclk(mclk),
      .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .eep_cs_n(eep_cs_n),
      .spr_cs_n(spr_cs_n), .rd_n(rd_n), .wr_n(wr_n)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string r, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
      end
   endtask

   function automatic int clampv(int v, int lo, int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic bit is_ext(int s);
      return s == 0 || s == 1 || s == 4 || s == 5;
   endfunction

   function automatic int exp_cs(bit rq, int s);
      if (!rq) return 4'hF;
      case (s)
         0: return 4'b1110;
         1: return 4'b1101;
         4: return 4'b1011;
         5: return 4'b0111;
         default: return 4'hF;
      endcase
   endfunction

   function automatic int exp_wr(bit rq, bit w, bit b, int s, int l);
      if (!(rq && w && is_ext(s))) return 4'hF;
      if (b && s == 1) return (~(1 << l)) & 4'hF;
      return 0;
   endfunction

   function automatic int exp_ws(bit rq, int s, int corr);
      if (!rq) return 0;
      case (s)
         0: return m_rom;
         4: return m_eep;
         5: return m_spr;
         3: return 1;
         2: return (corr != 0) ? 3 : 1;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(bit rq, int s);
      if (!rq) return "R4";
      case (s)
         0: return "R5";
         2: return "R8";
         3: return "R7";
         4, 5: return "R6";
         default: return "R4";
      endcase
   endfunction

   // one processor cycle: drive it, wait for its start, check previous length and current strobes
   task automatic step(input bit rq, input bit w, input bit b, input int s, input int l);
      int n = 0;
      int h = 0;
      bit fell = 0;
      int ws;
      req = rq; wr_en = w; byte_en = b; seg = 3'(s); lane = 2'(l);
      if (cfg_pend) begin
         wsr_we = 1'b1;
         m_rom = clampv(int'(wsr_rom), 1, 3);
         m_eep = clampv(int'(wsr_eep), 3, 6);
         m_spr = clampv(int'(wsr_spr), 3, 6);
         cfg_pend = 0;
      end
      while (!fell) begin
         @(negedge clk);
         n++;
         wsr_we = 1'b0;
         if (mclk) h++;
         fell = prev_mclk && !mclk;
         prev_mclk = mclk;
      end
      if (have_prev) begin
         chk({prev_tag, " cycle length"}, n, prev_len);
         chk("R11 high phase length", h, REF_DIV / 2);
      end
      chk("R1 chip selects", int'({spr_cs_n, eep_cs_n, ram_cs_n, rom_cs_n}), exp_cs(rq, s));
      chk("R2 read strobe", int'(rd_n), (rq && !w && is_ext(s)) ? 0 : 1);
      chk("R3 write strobes", int'(wr_n), exp_wr(rq, w, b, s, l));
      ws = exp_ws(rq, s, m_corr);
      prev_len = REF_DIV + REF_DIV * ws + (m_rec ? 1 : 0);
      prev_tag = m_rec ? "R9" : tag_of(rq, s);
      m_rec = rq && !w && (s == 0 || s == 4 || s == 5);
      if (rq && s == 2) m_corr = 2;
      else if (m_corr > 0) m_corr--;
      have_prev = 1;
   endtask

   task automatic cfg(input int r, input int e, input int s);
      wsr_rom = 3'(r); wsr_eep = 3'(e); wsr_spr = 3'(s);
      cfg_pend = 1;
   endtask

   always @(posedge clk) begin
      ticks++;
      if (ticks == 190000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected=<%0d", ticks, 190000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // reset state
      chk("R11 mclk in reset", int'(mclk), 1);
      chk("R11 selects in reset", int'({spr_cs_n, eep_cs_n, ram_cs_n, rom_cs_n}), 15);
      chk("R11 strobes in reset", int'({rd_n, wr_n}), 31);
      rst_n = 1'b1;
      prev_mclk = mclk;

      // R10 reset counts, R9 recovery after slow read
      step(1, 0, 0, 0, 0);   // ROM read, 3 waits
      step(0, 0, 0, 0, 0);   // idle with recovery tick
      step(1, 0, 0, 1, 0);   // RAM read
      step(1, 0, 0, 1, 2);   // RAM read: no recovery after it
      // R3 byte lanes on RAM
      for (int i = 0; i < 4; i++) step(1, 1, 1, 1, i);
      step(1, 1, 0, 1, 3);   // RAM word write
      step(1, 1, 1, 0, 2);   // byte write to ROM: all lanes
      step(1, 1, 1, 4, 1);   // byte write to EEPROM: all lanes
      // R10 clamping
      cfg(0, 7, 2);
      step(1, 0, 0, 0, 0);   // ROM: 1 wait
      step(1, 1, 0, 4, 0);   // EEPROM: 6 waits
      step(1, 1, 0, 5, 0);   // spare: 3 waits
      cfg(2, 4, 5);
      step(1, 0, 0, 5, 0);
      step(1, 0, 0, 4, 0);
      step(1, 0, 0, 0, 0);
      // R8 correlator spacing
      step(1, 0, 0, 2, 0);
      step(1, 1, 0, 2, 0);   // back to back
      step(0, 0, 0, 0, 0);
      step(1, 0, 0, 2, 0);   // one idle between
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      step(1, 0, 0, 2, 0);   // two idle between
      // R7 support, R1 unused codes
      step(1, 0, 0, 3, 0);
      step(1, 1, 0, 3, 0);
      step(1, 0, 0, 6, 0);
      step(1, 1, 1, 7, 1);
      step(1, 0, 0, 4, 0);
      step(1, 0, 0, 1, 0);   // RAM after EEPROM read carries recovery

      // random traffic
      for (int k = 0; k < 500; k++) begin
         int s;
         if ($urandom_range(0, 19) == 0)
            cfg($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
         s = ($urandom_range(0, 3) == 0) ? 2 : $urandom_range(0, 7);
         step($urandom_range(0, 6) != 0, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), s, $urandom_range(0, 3));
      end
      step(0, 0, 0, 0, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule